// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Repeat Masks

This block watches a running time of day, delivered as BCD fields (seconds, minutes, hours, day of month) by a separate clock core, and compares it against four programmable alarm fields. When the comparison succeeds on a one-second tick, the block emits a single-cycle interrupt pulse. Bit 7 of each alarm field is a "don't care" flag. The flags set on the slower fields build a hierarchy of repeat rates: once per month, once per day, once per hour, once per minute, or once per second. The block does not keep time itself.

Software reaches the block through a small byte-wide register window with a write strobe, an address and write data. Read data is combinational from the same address. An alarm field write whose value lies outside the legal BCD range for that field is dropped without any indication, and the stored value stays as it was. A fifth register holds an interrupt-enable byte that is stored and returned exactly as written. It does not gate the pulse.

Top module: `alarm_match_unit`

## Requirements
- R1: Register offsets are: 0 alarm seconds, 1 alarm minutes, 2 alarm hours, 3 alarm date, 4 interrupt enable. Every other offset reads 0x00 and ignores writes. After reset, all registers read 0x00 and the interrupt is low.
- R2: A write to alarm seconds or alarm minutes is stored in full (all 8 bits) only when bits 6:0 form BCD 00 to 59. Otherwise the register keeps its old value.
- R3: A write to alarm hours is stored in full only when bits 5:0 form BCD 00 to 23. Otherwise the register keeps its old value.
- R4: A write to alarm date is stored in full only when bits 4:0 are nonzero. Otherwise the register keeps its old value.
- R5: The interrupt-enable register reads back exactly the byte last written to it. Its value has no effect on the interrupt.
- R6: With all four bit-7 flags clear, a tick raises the interrupt only when date (bits 5:0), hours (bits 5:0), minutes (bits 6:0) and seconds (bits 6:0) all equal the time inputs (monthly).
- R7: With only the date flag set, a tick raises the interrupt when hours, minutes and seconds match (daily).
- R8: With the date and hours flags set and the others clear, a tick raises the interrupt when minutes and seconds match (hourly).
- R9: With the date, hours and minutes flags set and the seconds flag clear, a tick raises the interrupt when seconds match (every minute).
- R10: Any other flag combination, including any pattern with the seconds flag set, raises the interrupt on every tick.
- R11: The interrupt is high for exactly the one clock cycle after the cycle in which the tick is sampled high. It is never raised without a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| tod_sec | input | 7 | Current seconds, BCD |
| tod_min | input | 7 | Current minutes, BCD |
| tod_hour | input | 6 | Current hours, BCD |
| tod_date | input | 6 | Current day of month, BCD |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register offset for reads and writes |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| alarm_irq | output | 1 | Alarm interrupt pulse |

## Verification
The bench builds the block with the default ADDR_W of 3. With that width, every offset from 0 to 7 can be addressed, including the three unused offsets above the enable register, so reads of zero and dropped writes there are checked directly. The time inputs are driven straight from the bench rather than from a clock core. Any date, hour or minute boundary can therefore be applied on a chosen tick, without waiting for real time to pass.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;

    // Field offsets; the field index equals the register offset
    localparam int FIELD_COUNT = 4;
    localparam int OFS_SEC     = 0;
    localparam int OFS_MIN     = 1;
    localparam int OFS_HOUR    = 2;
    localparam int OFS_DATE    = 3;
    localparam int OFS_IE      = 4;
    localparam int BYTE_W      = 8;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] date;
    } alarm_regs_t;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [5:0] date;
    } tod_t;

    typedef enum logic [2:0] {
        RPT_MONTH,
        RPT_DAY,
        RPT_HOUR,
        RPT_MINUTE,
        RPT_SECOND
    } repeat_e;

    // Two-digit BCD value no greater than limit (limit given in BCD)
    function automatic logic bcd_in_range(input logic [7:0] v, input logic [7:0] limit);
        return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v <= limit);
    endfunction

    // Acceptance rule for a write to alarm field idx
    function automatic logic field_write_ok(input int idx, input logic [7:0] d);
        logic ok;
        case (idx)
            OFS_SEC, OFS_MIN: ok = bcd_in_range({1'b0, d[6:0]}, 8'h59);
            OFS_HOUR:         ok = bcd_in_range({2'b00, d[5:0]}, 8'h23);
            default:          ok = (d[4:0] != 5'd0);
        endcase
        return ok;
    endfunction

    // Repeat rate from the four don't-care flags
    function automatic repeat_e repeat_decode(input alarm_regs_t a);
        repeat_e r;
        case ({a.date[7], a.hour[7], a.min[7], a.sec[7]})
            4'b0000: r = RPT_MONTH;
            4'b1000: r = RPT_DAY;
            4'b1100: r = RPT_HOUR;
            4'b1110: r = RPT_MINUTE;
            default: r = RPT_SECOND;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
    import alarm_match_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output alarm_regs_t       alarm,
    output logic [7:0]        ie,
    output logic [7:0]        rdata
);

    logic [7:0] fld_q [FIELD_COUNT];
    logic [7:0] ie_q;

    for (genvar i = 0; i < FIELD_COUNT; i++) begin : g_fld
        logic hit;
        always_comb hit = wr_en && (addr == ADDR_W'(i)) && field_write_ok(i, wdata);

        always_ff @(posedge clk) begin
            if (rst) begin
                fld_q[i] <= '0;
            end else if (hit) begin
                fld_q[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q <= '0;
        end else if (wr_en && (addr == ADDR_W'(OFS_IE))) begin
            ie_q <= wdata;
        end
    end

    always_comb begin
        alarm.sec  = fld_q[OFS_SEC];
        alarm.min  = fld_q[OFS_MIN];
        alarm.hour = fld_q[OFS_HOUR];
        alarm.date = fld_q[OFS_DATE];
        ie         = ie_q;
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < FIELD_COUNT; k++) begin
            if (addr == ADDR_W'(k)) rdata = fld_q[k];
        end
        if (addr == ADDR_W'(OFS_IE)) rdata = ie_q;
    end

endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
    import alarm_match_pkg::*;
(
    input  alarm_regs_t alarm,
    input  tod_t        tod,
    output repeat_e     mode,
    output logic        hit
);

    logic sec_eq, min_eq, hour_eq, date_eq;

    always_comb begin
        sec_eq  = (alarm.sec[6:0]  == tod.sec);
        min_eq  = (alarm.min[6:0]  == tod.min);
        hour_eq = (alarm.hour[5:0] == tod.hour);
        date_eq = (alarm.date[5:0] == tod.date);
        mode    = repeat_decode(alarm);
        case (mode)
            RPT_MONTH:  hit = date_eq && hour_eq && min_eq && sec_eq;
            RPT_DAY:    hit = hour_eq && min_eq && sec_eq;
            RPT_HOUR:   hit = min_eq && sec_eq;
            RPT_MINUTE: hit = sec_eq;
            default:    hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/alarm_pulse.sv
module alarm_pulse (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hit,
    output logic irq
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= tick && hit;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alarm_match_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic [6:0]        tod_sec,
    input  logic [6:0]        tod_min,
    input  logic [5:0]        tod_hour,
    input  logic [5:0]        tod_date,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              alarm_irq
);

    alarm_regs_t alarm_q;
    logic [7:0]  ie_q;
    tod_t        tod;
    repeat_e     mode;
    logic        hit;

    always_comb begin
        tod.sec  = tod_sec;
        tod.min  = tod_min;
        tod.hour = tod_hour;
        tod.date = tod_date;
    end

    alarm_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .alarm (alarm_q),
        .ie    (ie_q),
        .rdata (rdata)
    );

    alarm_compare u_cmp (
        .alarm (alarm_q),
        .tod   (tod),
        .mode  (mode),
        .hit   (hit)
    );

    alarm_pulse u_pulse (
        .clk  (clk),
        .rst  (rst),
        .tick (sec_tick),
        .hit  (hit),
        .irq  (alarm_irq)
    );

endmodule

// File: rtl/alarm_match_unit_chk.sv
module alarm_match_unit_chk
    import alarm_match_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              sec_tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic              alarm_irq,
    input alarm_regs_t       alarm,
    input logic [7:0]        ie
);

    // R11
    irq_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> $past(sec_tick));

    // R11
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm_irq && !sec_tick) |=> !alarm_irq);

    // R2
    sec_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_SEC) && (wdata[3:0] > 4'd9 || wdata[6:4] > 3'd5))
        |=> $stable(alarm.sec));

    // R3
    hour_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_HOUR) &&
         (wdata[3:0] > 4'd9 || wdata[5:4] == 2'd3 || (wdata[5:4] == 2'd2 && wdata[3:0] > 4'd3)))
        |=> $stable(alarm.hour));

    // R4
    date_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_DATE) && wdata[4:0] == 5'd0) |=> $stable(alarm.date));

    // R5
    ie_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_IE)) |=> (ie == $past(wdata)));

    // R10
    sec_flag_fires_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && alarm.sec[7]) |=> alarm_irq);

endmodule

bind alarm_match_unit alarm_match_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sec_tick  (sec_tick),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .alarm_irq (alarm_irq),
    .alarm     (alarm_q),
    .ie        (ie_q)
);

// File: tb/alarm_match_unit_tb.sv
module alarm_match_unit_tb;

    localparam int ADDR_W = 3;

    typedef struct packed {
        logic [3:0] req;
        logic [7:0] a_sec, a_min, a_hour, a_date;
        logic [7:0] t_sec, t_min, t_hour, t_date;
        logic       exp;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{4'd6,  8'h30, 8'h45, 8'h12, 8'h15,  8'h30, 8'h45, 8'h12, 8'h15, 1'b1}, // R6 full match
        '{4'd6,  8'h30, 8'h45, 8'h12, 8'h15,  8'h30, 8'h45, 8'h12, 8'h16, 1'b0}, // R6 date differs
        '{4'd7,  8'h30, 8'h45, 8'h12, 8'h95,  8'h30, 8'h45, 8'h12, 8'h20, 1'b1}, // R7 daily
        '{4'd7,  8'h30, 8'h45, 8'h12, 8'h95,  8'h30, 8'h45, 8'h13, 8'h15, 1'b0}, // R7 hour differs
        '{4'd8,  8'h30, 8'h45, 8'h92, 8'h95,  8'h30, 8'h45, 8'h07, 8'h03, 1'b1}, // R8 hourly
        '{4'd8,  8'h30, 8'h45, 8'h92, 8'h95,  8'h30, 8'h46, 8'h12, 8'h15, 1'b0}, // R8 minute differs
        '{4'd9,  8'h30, 8'hC5, 8'h92, 8'h95,  8'h30, 8'h11, 8'h05, 8'h01, 1'b1}, // R9 per minute
        '{4'd9,  8'h30, 8'hC5, 8'h92, 8'h95,  8'h31, 8'h45, 8'h12, 8'h15, 1'b0}, // R9 second differs
        '{4'd10, 8'hB0, 8'hC5, 8'h92, 8'h95,  8'h01, 8'h02, 8'h03, 8'h04, 1'b1}, // R10 all flags
        '{4'd10, 8'hB0, 8'h45, 8'h12, 8'h15,  8'h01, 8'h02, 8'h03, 8'h04, 1'b1}, // R10 seconds flag only
        '{4'd10, 8'h30, 8'h45, 8'h92, 8'h15,  8'h01, 8'h02, 8'h03, 8'h04, 1'b1}, // R10 hours flag only
        '{4'd6,  8'h00, 8'h00, 8'h00, 8'h01,  8'h00, 8'h00, 8'h00, 8'h01, 1'b1}  // R6 zero boundary
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              sec_tick;
    logic [6:0]        tod_sec;
    logic [6:0]        tod_min;
    logic [5:0]        tod_hour;
    logic [5:0]        tod_date;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        wdata;
    logic [7:0]        rdata;
    logic              alarm_irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    alarm_match_unit #(.ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .sec_tick  (sec_tick),
        .tod_sec   (tod_sec),
        .tod_min   (tod_min),
        .tod_hour  (tod_hour),
        .tod_date  (tod_date),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .alarm_irq (alarm_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = ADDR_W'(a);
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input int a, input logic [7:0] exp);
        addr = ADDR_W'(a);
        #1;
        check(req, rdata, exp);
    endtask

    task automatic set_tod(input logic [7:0] s, input logic [7:0] m,
                           input logic [7:0] h, input logic [7:0] d);
        tod_sec  = s[6:0];
        tod_min  = m[6:0];
        tod_hour = h[5:0];
        tod_date = d[5:0];
    endtask

    // Pulse the tick, check the irq in the following cycle, then its fall
    task automatic tick_check(input string req, input logic exp);
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        check(req, {7'd0, alarm_irq}, {7'd0, exp});
        @(negedge clk);
        check("R11 pulse ends", {7'd0, alarm_irq}, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; sec_tick = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        set_tod(8'h00, 8'h00, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 8; a++) rd_check("R1 reset read", a, 8'h00);
        check("R1 reset irq", {7'd0, alarm_irq}, 8'h00);

        // Table walk: R6..R10 plus the R11 pulse shape
        for (int i = 0; i < NVEC; i++) begin
            wr(0, VECS[i].a_sec);
            wr(1, VECS[i].a_min);
            wr(2, VECS[i].a_hour);
            wr(3, VECS[i].a_date);
            set_tod(VECS[i].t_sec, VECS[i].t_min, VECS[i].t_hour, VECS[i].t_date);
            tick_check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp);
        end

        // R11 no pulse without a tick, even in every-second mode
        wr(0, 8'hB0);
        repeat (5) begin
            @(negedge clk);
            check("R11 no tick", {7'd0, alarm_irq}, 8'h00);
        end

        // R2 seconds and minutes range
        wr(0, 8'h12);
        wr(0, 8'h5A); rd_check("R2 bad low digit", 0, 8'h12);
        wr(0, 8'h60); rd_check("R2 sixty", 0, 8'h12);
        wr(0, 8'hD9); rd_check("R2 59 with flag", 0, 8'hD9);
        wr(1, 8'h21);
        wr(1, 8'h7F); rd_check("R2 minutes bad", 1, 8'h21);
        wr(1, 8'h59); rd_check("R2 minutes 59", 1, 8'h59);

        // R3 hours range
        wr(2, 8'h05);
        wr(2, 8'h24); rd_check("R3 hour 24", 2, 8'h05);
        wr(2, 8'h1A); rd_check("R3 bad digit", 2, 8'h05);
        wr(2, 8'h23); rd_check("R3 hour 23", 2, 8'h23);
        wr(2, 8'hE3); rd_check("R3 upper bits kept", 2, 8'hE3);

        // R4 date nonzero
        wr(3, 8'h07);
        wr(3, 8'hE0); rd_check("R4 zero low bits", 3, 8'h07);
        wr(3, 8'h1F); rd_check("R4 nonzero accepted", 3, 8'h1F);

        // R5 enable byte stored, no effect on the pulse
        wr(4, 8'hA5); rd_check("R5 readback", 4, 8'hA5);
        wr(4, 8'h00); rd_check("R5 readback zero", 4, 8'h00);
        wr(0, 8'hB0);
        tick_check("R5 irq with enable clear", 1'b1);

        // R1 unused offsets ignore writes
        wr(5, 8'hFF); rd_check("R1 unused 5", 5, 8'h00);
        wr(7, 8'h3C); rd_check("R1 unused 7", 7, 8'h00);
        rd_check("R1 neighbour intact", 4, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule